// File: doc/BRIEF.md
# Octal registered bus transceiver

This block joins two 8-bit buses, called A and B, and can pass a byte across in either direction. Each bus side is split into an input vector, an output vector and a per-bit output-enable vector. One control input isolates both sides, and a direction input picks the side that drives. Each direction owns a storage register with its own capture clock. A per-direction select input chooses whether the driven byte is the live value from the opposite bus or the byte held in that direction's register.

Capture never depends on the drive controls. A register takes its source bus on every rising edge of its own clock, even while the outputs are isolated or point the other way. This allows store-only and store-both operations with the buses isolated, and the stored bytes can be replayed later. The two capture clocks are independent of each other. An active-low asynchronous reset clears both registers.

Data moves as plain parallel buses with no handshake. A value is valid whenever it is driven and no back-pressure exists. Control pins are plain levels.

Top module: `octal_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers read zero. After reset, a side that drives in stored mode outputs 8'h00 until the first capture.
- R2: When `out_dis` is 1, every bit of `a_oe` and `b_oe` is 0, whatever the values of `dir_a2b` and the select inputs.
- R3: When `out_dis` is 0 and `dir_a2b` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R4: When `out_dis` is 0 and `dir_a2b` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R5: With `ab_use_reg` at 0, `b_out` equals `a_in` combinationally, in the same cycle as the input change, with no register delay.
- R6: With `ab_use_reg` at 1, `b_out` equals the byte last captured from `a_in` on a rising edge of `ab_clk`.
- R7: `ba_use_reg` selects the same way for `a_out`. At 0, `a_out` follows `b_in` live. At 1, `a_out` shows the byte captured from `b_in` on the last rising edge of `ba_clk`.
- R8: Each register changes only on a rising edge of its own clock. A rising edge of `ba_clk` leaves the byte captured from A unchanged.
- R9: Capture happens whatever the values of `out_dis` and `dir_a2b`. Both registers can be loaded while the buses are isolated.
- R10: Capturing an undefined input on the side that is being driven leaves the other direction's stored byte unchanged.
- R11: `a_oe` and `b_oe` are never both non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| ab_clk | input | 1 | Capture clock of the A-to-B register, rising edge |
| ba_clk | input | 1 | Capture clock of the B-to-A register, rising edge |
| out_dis | input | 1 | 1 isolates both buses |
| dir_a2b | input | 1 | 1 drives B from A, 0 drives A from B |
| ab_use_reg | input | 1 | 1 shows the stored A byte on B, 0 shows live A |
| ba_use_reg | input | 1 | 1 shows the stored B byte on A, 0 shows live B |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Byte offered to bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Byte offered to bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
Live mode is tried with alternating, inverted, all-ones and all-zeros bytes. These separate a correct pass-through from stuck, swapped or inverted bits. Stored mode captures a byte and then changes the live input, so a mux that picks the wrong leg shows at once. Captures on one clock, and captures while the buses are isolated or driven the other way, separate a register that follows its own clock from one that is gated by the drive controls or clocked by its neighbour. An undefined byte captured on the driven side checks that the fault stays in its own register.

// File: rtl/octal_xcvr_pkg.sv
package octal_xcvr_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } drive_side_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             use_reg,
  output logic [WIDTH-1:0] dout
);
  always_comb begin
    dout = use_reg ? stored : live;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import octal_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             out_dis,
  input  logic             dir_a2b,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_oe
);
  drive_side_e side;

  always_comb begin
    if (out_dis)      side = SIDE_NONE;
    else if (dir_a2b) side = SIDE_B;
    else              side = SIDE_A;
    a_oe = {WIDTH{side == SIDE_A}};
    b_oe = {WIDTH{side == SIDE_B}};
  end

  // R11: the two sides never drive together
  always_comb begin
    assert_single_side_R11: assert (!((|a_oe) && (|b_oe)));
  end
endmodule

// File: rtl/octal_bus_xcvr.sv
module octal_bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             ab_clk,
  input  logic             ba_clk,
  input  logic             out_dis,
  input  logic             dir_a2b,
  input  logic             ab_use_reg,
  input  logic             ba_use_reg,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  localparam int NDIR = 2;   // index 0: A toward B, index 1: B toward A

  logic [NDIR-1:0]  cap_clk;
  logic [NDIR-1:0]  sel_reg;
  logic [WIDTH-1:0] src   [NDIR];
  logic [WIDTH-1:0] held  [NDIR];
  logic [WIDTH-1:0] pout  [NDIR];

  always_comb begin
    cap_clk = {ba_clk, ab_clk};
    sel_reg = {ba_use_reg, ab_use_reg};
    src[0]  = a_in;
    src[1]  = b_in;
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcvr_store_reg #(.WIDTH(WIDTH)) u_store (
      .clk   (cap_clk[g]),
      .rst_n (rst_n),
      .d     (src[g]),
      .q     (held[g])
    );
    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
      .live    (src[g]),
      .stored  (held[g]),
      .use_reg (sel_reg[g]),
      .dout    (pout[g])
    );
  end

  xcvr_drive_ctl #(.WIDTH(WIDTH)) u_ctl (
    .out_dis (out_dis),
    .dir_a2b (dir_a2b),
    .a_oe    (a_oe),
    .b_oe    (b_oe)
  );

  assign b_out = pout[0];
  assign a_out = pout[1];

  always_comb begin
    if (rst_n) begin
      // R2: isolation wins over direction
      assert_isolate_R2: assert (!out_dis || (a_oe == '0 && b_oe == '0));
      // R3: direction high drives B only
      assert_dir_b_R3: assert (out_dis || !dir_a2b || (&b_oe && a_oe == '0));
      // R4: direction low drives A only
      assert_dir_a_R4: assert (out_dis || dir_a2b || (&a_oe && b_oe == '0));
      // R5: live path toward B is combinational
      assert_live_ab_R5: assert (ab_use_reg || b_out == a_in);
      // R6: stored path toward B shows the A register
      assert_held_ab_R6: assert (!ab_use_reg || b_out == held[0]);
      // R7: select toward A picks live or stored
      assert_sel_ba_R7: assert (ba_use_reg ? (a_out == held[1]) : (a_out == b_in));
    end else begin
      // R1: reset clears both registers
      assert_reset_clear_R1: assert (held[0] == '0 && held[1] == '0);
    end
  end
endmodule

// File: tb/octal_bus_xcvr_tb.sv
module octal_bus_xcvr_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ab_clk = 1'b0;
  logic         ba_clk = 1'b0;
  logic         out_dis = 1'b1;
  logic         dir_a2b = 1'b1;
  logic         ab_use_reg = 1'b0;
  logic         ba_use_reg = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [W-1:0] m_ab = '0;
  logic [W-1:0] m_ba = '0;

  always #10 clk = ~clk;

  octal_bus_xcvr #(.WIDTH(W)) u_dut (
    .rst_n(rst_n), .ab_clk(ab_clk), .ba_clk(ba_clk),
    .out_dis(out_dis), .dir_a2b(dir_a2b),
    .ab_use_reg(ab_use_reg), .ba_use_reg(ba_use_reg),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [W-1:0] e_aoe, e_boe;
      e_aoe = (!out_dis && !dir_a2b) ? '1 : '0;
      e_boe = (!out_dis &&  dir_a2b) ? '1 : '0;
      check(out_dis ? "R2 a_oe" : "R4 a_oe", a_oe, e_aoe);
      check(out_dis ? "R2 b_oe" : "R3 b_oe", b_oe, e_boe);
      if (e_boe[0]) check(ab_use_reg ? "R6 b_out" : "R5 b_out", b_out, ab_use_reg ? m_ab : a_in);
      if (e_aoe[0]) check("R7 a_out", a_out, ba_use_reg ? m_ba : b_in);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input bit do_ab, input bit do_ba);
    @(posedge clk); #2;
    if (do_ab) begin ab_clk = 1'b1; m_ab = a_in; end
    if (do_ba) begin ba_clk = 1'b1; m_ba = b_in; end
    #6;
    ab_clk = 1'b0;
    ba_clk = 1'b0;
  endtask

  initial begin
    // reset state
    repeat (2) step();
    out_dis = 1'b0; dir_a2b = 1'b1; ab_use_reg = 1'b1; ba_use_reg = 1'b1;
    a_in = 8'hC3; b_in = 8'h3C;
    #2;
    check("R1 b_out in reset", b_out, 8'h00);
    check("R1 a_oe in reset", a_oe, 8'h00);
    step(); rst_n = 1'b1;
    cmp_on = 1'b1;
    step(); #2;
    check("R1 b_out after reset", b_out, 8'h00);
    dir_a2b = 1'b0; #2;
    check("R1 a_out after reset", a_out, 8'h00);
    check("R4 a_oe", a_oe, 8'hFF);

    // live A to B, checked in the same cycle as each change
    dir_a2b = 1'b1; ab_use_reg = 1'b0;
    foreach (a_in[i]) begin end
    for (int k = 0; k < 4; k++) begin
      step();
      a_in = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'h00;
      #1;
      check("R5 live b_out", b_out, a_in);
      check("R3 b_oe", b_oe, 8'hFF);
    end

    // stored A to B
    step(); a_in = 8'h3C;
    pulse(1'b1, 1'b0);
    step(); a_in = 8'h99; ab_use_reg = 1'b1; #1;
    check("R6 stored b_out", b_out, 8'h3C);

    // B to A, stored then live
    step(); dir_a2b = 1'b0; b_in = 8'h81;
    pulse(1'b0, 1'b1);
    step(); b_in = 8'h42; #1;
    check("R7 stored a_out", a_out, 8'h81);
    ba_use_reg = 1'b0; #1;
    check("R7 live a_out", a_out, 8'h42);

    // other clock leaves the A register alone
    step(); a_in = 8'hE7;
    pulse(1'b0, 1'b1);
    step(); dir_a2b = 1'b1; #1;
    check("R8 A register after B edge", b_out, 8'h3C);

    // store both while isolated
    step(); out_dis = 1'b1; a_in = 8'h77; b_in = 8'h11; #1;
    check("R2 a_oe isolated", a_oe, 8'h00);
    check("R2 b_oe isolated", b_oe, 8'h00);
    pulse(1'b1, 1'b1);
    step(); out_dis = 1'b0; dir_a2b = 1'b1; ab_use_reg = 1'b1; #1;
    check("R9 A byte stored while isolated", b_out, 8'h77);
    dir_a2b = 1'b0; ba_use_reg = 1'b1; #1;
    check("R9 B byte stored while isolated", a_out, 8'h11);

    // capture on the driven side with an undefined bus value
    step(); dir_a2b = 1'b1; b_in = 'x;
    pulse(1'b0, 1'b1);
    step(); #1;
    check("R10 A register after undefined B capture", b_out, 8'h77);
    b_in = 8'h6E;
    pulse(1'b0, 1'b1);
    step(); dir_a2b = 1'b0; #1;
    check("R10 B register reloaded", a_out, 8'h6E);
    check("R11 single side", {7'd0, (|a_oe) && (|b_oe)}, 8'h00);

    repeat (3) step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule